// File: doc/BRIEF.md
# UART Interrupt Enable and Identification Logic

This block holds the interrupt enable register of a 16550-style serial port, produces the interrupt identification value and drives the port's single interrupt line. It sits on a byte-wide register bus with an address, a write strobe, a read strobe and write and read data. Four interrupt sources feed it: line-status error flags, a receive-data-available flag, a transmit-empty pending flag kept inside the block, and modem-status change flags. Each source is gated by its own enable bit. The highest-priority source that is both enabled and active is reported through the identification register. The line and modem inputs are levels that are cleared elsewhere, by reads of the line and modem status registers.

The transmit-empty source is a sticky pending flag, not a live transmitter signal. Reset sets it. A read of the identification register that reports it clears it. An enable-register write that keeps the transmit-empty enable set sets it again. When the divisor-latch access bit, an input from the line control register, is high, offsets 0 and 1 reach the two divisor latch bytes instead. The divisor is driven out to the baud generator.

Top module: `uart_irq_ident`

## Requirements
- R1: The reported cause follows a fixed priority, highest first: line status (code 0x6), received data (0x4), transmit empty (0x2), modem status (0x0). Only one code is reported, in bits 3:0 of the identification value read at offset 2.
- R2: Enable bits are IER bit 0 for received data, bit 1 for transmit empty, bit 2 for line status and bit 3 for modem status. A cause whose enable bit is clear is never reported. Writes to IER at offset 1 keep only bits 3:0, and bits 7:4 read back as 0.
- R3: When no enabled cause is active, bits 3:0 of the identification value read 0x1.
- R4: Identification bits 7:6 read 11 when fifo_en_i is high and 00 when it is low. Bits 5:4 always read 0.
- R5: irq_o is a register. After each clock edge it is high exactly when the identification value just before that edge showed a pending cause.
- R6: Reset clears IER, sets the transmit-empty pending flag, loads the divisor with DIV_RST and drives irq_o low.
- R7: A read of offset 2 that reports transmit empty clears the transmit-empty pending flag. A read that reports any other code leaves the flag unchanged.
- R8: A write to IER with bit 1 set, while IER bit 1 is already set, sets the transmit-empty pending flag. Setting bit 1 when it was clear does not set the flag.
- R9: With dlab_i high, offsets 0 and 1 write and read the divisor low and high bytes (divisor_o = {high, low}). IER and the pending flag are left unchanged, and offset 2 still returns the identification value.
- R10: A write to offset 2 changes no interrupt state: the IER, the pending flag, the identification value and irq_o stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from offset and state |
| dlab_i | input | 1 | Divisor-latch access bit from line control |
| line_err_i | input | LSR_W | Line-status error flags (level) |
| rx_avail_i | input | 1 | Received data available (level) |
| modem_chg_i | input | MSR_W | Modem-status change flags (level) |
| fifo_en_i | input | 1 | FIFO enable bit from FIFO control |
| divisor_o | output | 16 | Divisor latch value |
| irq_o | output | 1 | Interrupt line |

## Verification
The bound assertions check several rules on every cycle. Every identification read returns one of the five legal codes, with FIFO bits that follow fifo_en_i. An enabled line error always wins. irq_o follows the pending state of the previous identification read. A reported transmit-empty clears its flag, and a same-enable rewrite re-arms it. Divisor-latch writes never touch IER. The bench's reference model checks irq_o and the divisor on every clock. Only the scripted scenarios show that a 0-to-1 enable does not re-arm, that a read reporting another cause leaves the flag in place, and that writes at offset 2 and under DLAB leave the interrupt state as it was.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int N_CAUSE = 4;
  localparam int IER_W   = 4;

  // cause index == priority rank, 0 highest
  localparam int C_LINE = 0;
  localparam int C_RXD  = 1;
  localparam int C_TXE  = 2;
  localparam int C_MDM  = 3;

  // enable bit positions inside IER
  localparam int EN_RXD  = 0;
  localparam int EN_TXE  = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;

  localparam int A_DATA = 0;
  localparam int A_IER  = 1;
  localparam int A_IIR  = 2;

  localparam logic [3:0] CODE_NONE = 4'h1;

  function automatic logic [3:0] cause_code(input int idx);
    case (idx)
      C_LINE:  return 4'h6;
      C_RXD:   return 4'h4;
      C_TXE:   return 4'h2;
      default: return 4'h0;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
#(
  parameter logic [15:0] DIV_RST = 16'h000C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ier_we_i,
  input  logic             dll_we_i,
  input  logic             dlm_we_i,
  input  logic             txe_clr_i,
  input  logic [7:0]       wdata_i,
  output logic [IER_W-1:0] ier_o,
  output logic             txe_pend_o,
  output logic [15:0]      divisor_o
);
  logic [IER_W-1:0] ier_q;
  logic             txe_q;
  logic [7:0]       dll_q, dlm_q;
  logic             rearm;

  // re-arm only when enable is kept set, not on 0->1
  assign rearm = ier_we_i && wdata_i[EN_TXE] && ier_q[EN_TXE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_q <= '0;
      txe_q <= 1'b1;
      dll_q <= DIV_RST[7:0];
      dlm_q <= DIV_RST[15:8];
    end else begin
      if (ier_we_i) ier_q <= wdata_i[IER_W-1:0];
      if (rearm)          txe_q <= 1'b1;
      else if (txe_clr_i) txe_q <= 1'b0;
      if (dll_we_i) dll_q <= wdata_i;
      if (dlm_we_i) dlm_q <= wdata_i;
    end
  end

  assign ier_o      = ier_q;
  assign txe_pend_o = txe_q;
  assign divisor_o  = {dlm_q, dll_q};
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  for (genvar i = 0; i < N; i++) begin : g_rank
    if (i == 0) begin : g_top
      assign grant_o[i] = req_i[i];
    end else begin : g_low
      assign grant_o[i] = req_i[i] && !(|req_i[i-1:0]);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int          ADDR_W  = 3,
  parameter int          LSR_W   = 4,
  parameter int          MSR_W   = 4,
  parameter logic [15:0] DIV_RST = 16'h000C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              dlab_i,
  input  logic [LSR_W-1:0]  line_err_i,
  input  logic              rx_avail_i,
  input  logic [MSR_W-1:0]  modem_chg_i,
  input  logic              fifo_en_i,
  output logic [15:0]       divisor_o,
  output logic              irq_o
);
  logic [IER_W-1:0]   ier_q;
  logic               thre_q;
  logic [N_CAUSE-1:0] req, grant;
  logic               any_pend;
  logic [3:0]         code;
  logic [7:0]         iir_val;
  logic               sel_data, sel_ier, sel_iir;
  logic               irq_q;

  assign sel_data = addr_i == ADDR_W'(A_DATA);
  assign sel_ier  = addr_i == ADDR_W'(A_IER);
  assign sel_iir  = addr_i == ADDR_W'(A_IIR);

  uart_irq_regs #(.DIV_RST(DIV_RST)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ier_we_i   (wr_i && !dlab_i && sel_ier),
    .dll_we_i   (wr_i && dlab_i && sel_data),
    .dlm_we_i   (wr_i && dlab_i && sel_ier),
    .txe_clr_i  (rd_i && sel_iir && grant[C_TXE]),
    .wdata_i    (wdata_i),
    .ier_o      (ier_q),
    .txe_pend_o (thre_q),
    .divisor_o  (divisor_o)
  );

  assign req[C_LINE] = ier_q[EN_LINE] && (|line_err_i);
  assign req[C_RXD]  = ier_q[EN_RXD]  && rx_avail_i;
  assign req[C_TXE]  = ier_q[EN_TXE]  && thre_q;
  assign req[C_MDM]  = ier_q[EN_MDM]  && (|modem_chg_i);

  uart_irq_prio #(.N(N_CAUSE)) u_prio (
    .req_i   (req),
    .grant_o (grant),
    .any_o   (any_pend)
  );

  always_comb begin
    code = CODE_NONE;
    for (int i = 0; i < N_CAUSE; i++)
      if (grant[i]) code = cause_code(i);
  end

  assign iir_val = {{2{fifo_en_i}}, 2'b00, code};

  always_comb begin
    rdata_o = '0;
    if (sel_iir)                rdata_o = iir_val;
    else if (dlab_i && sel_data) rdata_o = divisor_o[7:0];
    else if (dlab_i && sel_ier)  rdata_o = divisor_o[15:8];
    else if (sel_ier)            rdata_o = {{(8-IER_W){1'b0}}, ier_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= any_pend;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int ADDR_W = 3,
  parameter int LSR_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic              dlab_i,
  input logic [LSR_W-1:0]  line_err_i,
  input logic              fifo_en_i,
  input logic              irq_o,
  input logic [3:0]        ier_q,
  input logic              thre_q
);
  logic rd_iir;
  assign rd_iir = rd_i && addr_i == ADDR_W'(2);

  a_r3_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_iir |-> (rdata_o[3:0] inside {4'h1, 4'h6, 4'h4, 4'h2, 4'h0}) && rdata_o[5:4] == 2'b00);

  a_r4_fifo_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_iir |-> rdata_o[7:6] == {2{fifo_en_i}});

  a_r1_line_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_iir && ier_q[2] && (|line_err_i)) |-> rdata_o[3:0] == 4'h6);

  a_r5_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_iir |=> irq_o == !$past(rdata_o[0]));

  a_r7_txe_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_iir && !wr_i && rdata_o[3:0] == 4'h2) |=> !thre_q);

  a_r8_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !dlab_i && addr_i == ADDR_W'(1) && wdata_i[1] && ier_q[1]) |=> thre_q);

  a_r2_ier_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !dlab_i && addr_i == ADDR_W'(1)) |=> ier_q == $past(wdata_i[3:0]));

  a_r9_dlab_keeps_ier: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && dlab_i && addr_i <= ADDR_W'(1)) |=> $stable(ier_q));
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.ADDR_W(ADDR_W), .LSR_W(LSR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .dlab_i     (dlab_i),
  .line_err_i (line_err_i),
  .fifo_en_i  (fifo_en_i),
  .irq_o      (irq_o),
  .ier_q      (ier_q),
  .thre_q     (thre_q)
);

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  localparam int ADDR_W = 3;
  localparam int LSR_W  = 4;
  localparam int MSR_W  = 4;
  localparam logic [15:0] DIV_RST = 16'h000C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic dlab = 1'b0;
  logic [LSR_W-1:0] line_err = '0;
  logic rx_av = 1'b0;
  logic [MSR_W-1:0] modem = '0;
  logic fifo_en = 1'b0;
  logic [15:0] divisor;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_irq_ident #(.ADDR_W(ADDR_W), .LSR_W(LSR_W), .MSR_W(MSR_W), .DIV_RST(DIV_RST)) u_uart_irq_ident (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .dlab_i(dlab), .line_err_i(line_err),
    .rx_avail_i(rx_av), .modem_chg_i(modem), .fifo_en_i(fifo_en),
    .divisor_o(divisor), .irq_o(irq)
  );

  // reference model
  logic [3:0] m_ier;
  bit m_txe;
  logic [7:0] m_dll, m_dlm;
  bit m_irq;

  function automatic int m_code();
    if (m_ier[2] && line_err != 0) return 6;
    if (m_ier[0] && rx_av)         return 4;
    if (m_ier[1] && m_txe)         return 2;
    if (m_ier[3] && modem != 0)    return 0;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ier = '0; m_txe = 1'b1; m_dll = DIV_RST[7:0]; m_dlm = DIV_RST[15:8]; m_irq = 1'b0;
    end else begin
      int c;
      c = m_code();
      m_irq = (c != 1);
      if (rd && addr == 2 && c == 2) m_txe = 1'b0;
      if (wr && !dlab && addr == 1) begin
        if (wdata[1] && m_ier[1]) m_txe = 1'b1;
        m_ier = wdata[3:0];
      end
      if (wr && dlab && addr == 0) m_dll = wdata;
      if (wr && dlab && addr == 1) m_dlm = wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #1;
      chk(irq == m_irq, "R5 irq_o vs model", int'(irq), int'(m_irq));
      chk(divisor == {m_dlm, m_dll}, "R9 divisor vs model", int'(divisor), int'({m_dlm, m_dll}));
    end
  end

  task automatic wr_reg(input int a, input int d);
    @(negedge clk);
    addr = ADDR_W'(a); wdata = 8'(d); wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    @(negedge clk);
    addr = ADDR_W'(a); rd = 1'b1;
    #1;
    chk(rdata == 8'(exp), tag, int'(rdata), exp);
    @(posedge clk); #1;
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);
    chk(irq == 1'b0, "R6 irq after reset", int'(irq), 0);
    chk(divisor == DIV_RST, "R6 divisor after reset", int'(divisor), int'(DIV_RST));
    rd_chk(1, 8'h00, "R6 IER after reset");
    rd_chk(2, 8'h01, "R3 no cause enabled");

    wr_reg(1, 8'h02);
    idle(1);
    chk(irq == 1'b1, "R5 irq raised by txe", int'(irq), 1);
    rd_chk(2, 8'h02, "R7 txe reported");
    rd_chk(2, 8'h01, "R7 txe cleared by read");
    idle(1);
    chk(irq == 1'b0, "R5 irq dropped", int'(irq), 0);

    wr_reg(1, 8'h02);
    rd_chk(2, 8'h02, "R8 rearm on kept enable");
    wr_reg(1, 8'h00);
    wr_reg(1, 8'h02);
    rd_chk(2, 8'h01, "R8 no rearm on 0->1");

    wr_reg(1, 8'hFF);
    rd_chk(1, 8'h0F, "R2 IER masked");
    rd_chk(2, 8'h02, "R8 rearm via full write");

    line_err = 4'h2; rx_av = 1'b1; modem = 4'h1;
    rd_chk(2, 8'h06, "R1 line first");
    line_err = '0;
    rd_chk(2, 8'h04, "R1 rx second");
    rx_av = 1'b0;
    rd_chk(2, 8'h00, "R1 modem last");
    wr_reg(1, 8'h0F);
    rd_chk(2, 8'h02, "R1 txe above modem");
    rd_chk(2, 8'h00, "R1 modem after txe");
    wr_reg(1, 8'h0F);
    line_err = 4'h8;
    rd_chk(2, 8'h06, "R7 line read keeps txe");
    line_err = '0;
    rd_chk(2, 8'h02, "R7 txe still pending");
    modem = '0;
    rd_chk(2, 8'h01, "R3 all causes idle");

    wr_reg(1, 8'h01);
    line_err = 4'h1; modem = 4'h4;
    rd_chk(2, 8'h01, "R2 disabled causes hidden");
    rx_av = 1'b1;
    rd_chk(2, 8'h04, "R2 enabled rx shown");
    rx_av = 1'b0; line_err = '0; modem = '0;

    fifo_en = 1'b1;
    rd_chk(2, 8'hC1, "R4 fifo bits no cause");
    rx_av = 1'b1;
    rd_chk(2, 8'hC4, "R4 fifo bits rx");
    rx_av = 1'b0; fifo_en = 1'b0;

    wr_reg(1, 8'h03);
    rx_av = 1'b1;
    wr_reg(2, 8'hFF);
    rd_chk(2, 8'h04, "R10 offset 2 write ignored");
    rd_chk(1, 8'h03, "R10 IER kept");
    rx_av = 1'b0;
    wr_reg(2, 8'h02);
    rd_chk(2, 8'h01, "R10 no rearm via offset 2");

    dlab = 1'b1;
    wr_reg(0, 8'h34);
    wr_reg(1, 8'h12);
    rd_chk(0, 8'h34, "R9 divisor low");
    rd_chk(1, 8'h12, "R9 divisor high");
    rd_chk(2, 8'h01, "R9 IIR under dlab");
    chk(divisor == 16'h1234, "R9 divisor_o", int'(divisor), 16'h1234);
    dlab = 1'b0;
    rd_chk(1, 8'h03, "R9 IER untouched");
    rd_chk(2, 8'h01, "R9 no rearm under dlab");

    wr_reg(1, 8'h04);
    line_err = 4'h1;
    idle(2);
    chk(irq == 1'b1, "R5 irq from line", int'(irq), 1);
    line_err = '0;
    idle(2);
    chk(irq == 1'b0, "R5 irq released", int'(irq), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 0x1 expected 0x0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule